// File: doc/BRIEF.md
# Set/Clear Clock Gate Register Bank

This block holds the on/off state of a group of gated clocks and exposes it through three word-aligned registers on a simple synchronous bus. Software never rewrites the whole state word. To switch a clock on it writes a mask to the set address. To switch a clock off it writes a mask to the clear address. The current state is read back from a third, read-only address. Bit n of every register belongs to gated clock n, so two agents can switch different clocks without a read-modify-write race.

Each state bit drives an enable output. It also drives a latch-based clock gating cell that passes a per-bit source clock. The latch is transparent only while its source clock is low, so a change of enable takes effect on the next low phase. The gated clock never carries a shortened high pulse.

The power-on state of every bit comes from a parameter. It is loaded while reset is asserted. The reset input is asynchronous and active-low, and its release is synchronised to the bus clock over two flops.

Top module: `clk_gate_bank`

## Requirements
- R1: Register byte offsets are fixed: status word at 0x0, set (enable) word at 0x4, clear (disable) word at 0x8; bit n of each word belongs to gated clock n.
- R2: A write to 0x4 turns on every clock whose data bit is 1, possibly several in one write, and leaves clocks whose data bit is 0 unchanged; the new state is visible from the bus clock edge that captures the write.
- R3: A write to 0x8 turns off every clock whose data bit is 1 and leaves clocks whose data bit is 0 unchanged, visible from the capturing edge.
- R4: A read of 0x0 returns the current state in the same cycle, bit n = 1 when clock n is on, and the enable output vector equals that state.
- R5: While reset is asserted, and after it is released, before any write, the state equals the RESET_EN parameter (default 0x0000A5C3).
- R6: Writes to 0x0 and to any address other than 0x4 and 0x8, unaligned ones included, leave the state unchanged.
- R7: Reads of 0x4, 0x8 and of every address other than 0x0 return zero.
- R8: Gated clock n equals source clock n AND an enable captured only while source clock n is low; an enable change while the source clock is high leaves the gated clock high until the source clock falls.
- R9: Set and clear writes to disjoint bits do not disturb each other: clearing bit m after setting bit k (k != m) keeps bit k on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and state register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address inside the group |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data, used as a set or clear mask |
| bus_rdata | output | DATA_W (32) | Combinational read data |
| src_clk | input | NUM_GATES (32) | Source clock for each gate |
| gate_en | output | NUM_GATES (32) | Current enable state of each gate |
| gclk | output | NUM_GATES (32) | Gated clock outputs |

## Verification
The hardest condition to reach from the ports is an enable change that lands while a source clock is high. A gate that is not built on a latch would truncate the pulse there. The bench drives the source clocks itself. It raises source clock 0, writes a disable mask during the high phase, and checks that the gated output stays high. The output may fall only after the source clock falls, and it must stay low on the next high phase. Walking set and clear sweeps over all 32 bits, and writes to every undecoded address, are checked against a mask model kept in the bench.

// File: rtl/cgb_pkg.sv
package cgb_pkg;
  localparam int unsigned OFS_STATUS = 32'h0;
  localparam int unsigned OFS_SET    = 32'h4;
  localparam int unsigned OFS_CLEAR  = 32'h8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_SET    = 2'd2,
    SEL_CLEAR  = 2'd3
  } cgb_sel_e;
endpackage

// File: rtl/cgb_rst_sync.sv
module cgb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/cgb_decode.sv
module cgb_decode
  import cgb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output cgb_sel_e          sel,
  output logic              set_wr,
  output logic              clr_wr
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);

  always_comb begin
    sel = SEL_NONE;
    if (addr == A_STATUS)     sel = SEL_STATUS;
    else if (addr == A_SET)   sel = SEL_SET;
    else if (addr == A_CLEAR) sel = SEL_CLEAR;
  end

  assign set_wr = wr && (sel == SEL_SET);
  assign clr_wr = wr && (sel == SEL_CLEAR);
endmodule

// File: rtl/cgb_state.sv
module cgb_state #(
  parameter int unsigned          NUM_GATES = 32,
  parameter logic [NUM_GATES-1:0] RESET_EN  = '0
) (
  input  logic                 clk,
  input  logic                 srst_n,
  input  logic                 set_wr,
  input  logic                 clr_wr,
  input  logic [NUM_GATES-1:0] mask,
  output logic [NUM_GATES-1:0] state
);
  logic [NUM_GATES-1:0] set_mask;
  logic [NUM_GATES-1:0] clr_mask;
  logic [NUM_GATES-1:0] state_d;
  logic [NUM_GATES-1:0] state_q;
  logic                 state_ce;

  always_comb begin
    set_mask = set_wr ? mask : '0;
    clr_mask = clr_wr ? mask : '0;
    state_ce = set_wr || clr_wr;
    state_d  = (state_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= RESET_EN;
    end else if (state_ce) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  AST_SET_BITS_ON: assert property (@(posedge clk) disable iff (!srst_n)
    set_wr |=> ((state_q & $past(mask)) == $past(mask))); // R2
  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!srst_n)
    set_wr |=> ((state_q & ~$past(mask)) == ($past(state_q) & ~$past(mask)))); // R9
  AST_CLR_BITS_OFF: assert property (@(posedge clk) disable iff (!srst_n)
    clr_wr |=> ((state_q & $past(mask)) == '0)); // R3
  AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!srst_n)
    clr_wr |=> ((state_q & ~$past(mask)) == ($past(state_q) & ~$past(mask)))); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (!set_wr && !clr_wr) |=> $stable(state_q)); // R6
endmodule

// File: rtl/cgb_gate_cell.sv
module cgb_gate_cell (
  input  logic src_clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!src_clk) en_lat = en;
  end

  assign gclk = src_clk & en_lat;
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import cgb_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 4,
  parameter int unsigned          DATA_W    = 32,
  parameter int unsigned          NUM_GATES = 32,
  parameter logic [NUM_GATES-1:0] RESET_EN  = NUM_GATES'(32'h0000_A5C3)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_GATES-1:0] src_clk,
  output logic [NUM_GATES-1:0] gate_en,
  output logic [NUM_GATES-1:0] gclk
);
  localparam int unsigned PAD_W = DATA_W - NUM_GATES;

  logic                 srst_n;
  cgb_sel_e             sel;
  logic                 set_wr;
  logic                 clr_wr;
  logic [NUM_GATES-1:0] state;

  cgb_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cgb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .sel    (sel),
    .set_wr (set_wr),
    .clr_wr (clr_wr)
  );

  cgb_state #(.NUM_GATES(NUM_GATES), .RESET_EN(RESET_EN)) u_state (
    .clk    (clk),
    .srst_n (srst_n),
    .set_wr (set_wr),
    .clr_wr (clr_wr),
    .mask   (bus_wdata[NUM_GATES-1:0]),
    .state  (state)
  );

  generate
    if (PAD_W == 0) begin : g_full
      assign bus_rdata = (sel == SEL_STATUS) ? state : '0;
    end else begin : g_pad
      assign bus_rdata = (sel == SEL_STATUS) ? {{PAD_W{1'b0}}, state} : '0;
    end
  endgenerate

  assign gate_en = state;

  for (genvar gi = 0; gi < NUM_GATES; gi++) begin : g_cell
    cgb_gate_cell u_cell (
      .src_clk (src_clk[gi]),
      .en      (state[gi]),
      .gclk    (gclk[gi])
    );
  end

  AST_NONSTATUS_READ_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr != ADDR_W'(OFS_STATUS)) |-> (bus_rdata == '0)); // R7
  AST_STATUS_READ_STATE: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr == ADDR_W'(OFS_STATUS)) |-> (bus_rdata[NUM_GATES-1:0] == gate_en)); // R4
endmodule

// File: tb/clk_gate_bank_test.sv
module clk_gate_bank_test;
  localparam int unsigned N = 32;
  localparam logic [31:0] RST_VAL = 32'h0000_A5C3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [N-1:0] src_clk;
  logic [N-1:0] gate_en;
  logic [N-1:0] gclk;

  int tests = 0;
  int fails = 0;
  logic [31:0] model;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clk_gate_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_clk   (src_clk),
    .gate_en   (gate_en),
    .gclk      (gclk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd_status(input string req);
    bus_addr = 4'h0;
    #1;
    check(req, bus_rdata, model);
    check(req, gate_en, model);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 4'h0; bus_wr = 1'b0; bus_wdata = '0; src_clk = '0;
    model = RST_VAL;
    repeat (3) @(negedge clk);
    rd_status("R5 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_status("R5 after release");

    // R2: walking set from zero, with a prior full clear (R3)
    wr(4'h8, 32'hFFFF_FFFF); model = '0;
    rd_status("R3 full clear");
    for (int i = 0; i < N; i++) begin
      wr(4'h4, 32'h1 << i); model |= (32'h1 << i);
      rd_status("R2 walking set");
    end
    // R3: walking clear
    for (int i = 0; i < N; i++) begin
      wr(4'h8, 32'h1 << i); model &= ~(32'h1 << i);
      rd_status("R3 walking clear");
    end
    // R2/R9: multi-bit set, then disjoint set and clear
    wr(4'h4, 32'h8000_0181); model = 32'h8000_0181;
    rd_status("R2 multi-bit set");
    wr(4'h4, 32'h0000_0000);
    rd_status("R2 zero mask holds");
    wr(4'h8, 32'h0000_0100); model = 32'h8000_0081;
    rd_status("R9 clear disjoint bit");
    wr(4'h4, 32'h0F00_0000); model = 32'h8F00_0081;
    rd_status("R9 set disjoint bits");
    // R6: ignored writes at status and every undecoded address
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 8) begin
        wr(4'(a), 32'hFFFF_FFFF);
        rd_status("R6 ignored write all ones");
        wr(4'(a), 32'h0);
        rd_status("R6 ignored write zero");
      end
    end
    // R7/R1: read of every non-status address is zero
    for (int a = 1; a < 16; a++) begin
      @(negedge clk);
      bus_addr = 4'(a);
      #1;
      check("R7 non-status read zero", bus_rdata, 32'h0);
    end
    bus_addr = 4'h0;
    rd_status("R1 status offset");

    // R8: latch-based gating on bit 0
    wr(4'h4, 32'h1); model |= 32'h1;
    @(negedge clk); src_clk[0] = 1'b1; #1;
    check("R8 gated high when enabled", {31'b0, gclk[0]}, 32'h1);
    @(negedge clk); bus_addr = 4'h8; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 4'h0; model &= ~32'h1; #1;
    check("R8 disabled state seen", {31'b0, gate_en[0]}, 32'h0);
    check("R8 no truncation while src high", {31'b0, gclk[0]}, 32'h1);
    src_clk[0] = 1'b0; #1;
    check("R8 low after src falls", {31'b0, gclk[0]}, 32'h0);
    src_clk[0] = 1'b1; #1;
    check("R8 stays low next high phase", {31'b0, gclk[0]}, 32'h0);
    src_clk[0] = 1'b0; #1;
    // R8: enable while src low passes next high
    wr(4'h4, 32'h1); model |= 32'h1;
    src_clk[0] = 1'b1; #1;
    check("R8 re-enabled pulse passes", {31'b0, gclk[0]}, 32'h1);
    src_clk[0] = 1'b0; #1;

    // R5: reset mid-run restores parameter value
    @(negedge clk); rst_n = 1'b0; model = RST_VAL; #1;
    rd_status("R5 reset mid-run");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_status("R5 after second release");

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule